// File: doc/BRIEF.md
# Global Compare Timer

This block is a memory-mapped system timer. It has a 64-bit up-counter that software can start, stop and load one 32-bit half at a time. A single 64-bit comparator watches the counter. When the comparator is enabled and the counter equals the programmed compare value, a sticky pending flag is raised. The interrupt line is driven while that flag is set and its enable bit is on.

The comparator can also re-arm itself. If auto-increment is turned on, every match adds a programmed 32-bit step to the compare value, which gives a periodic event with no software work per period. Software learns that each register write has taken effect by polling write-confirmation bits. These bits are sticky and are cleared by writing 1 to them. The bus is a plain 32-bit register port. Reads are combinational, and a write is accepted on the clock edge where the write strobe is high.

Top module: `gtmr_global_timer`

## Requirements
- R1: After reset the counter, compare value, step, control, enable, pending and all confirmation bits read as zero, and `irqOut` is low.
- R2: A write to 0x100 replaces only bits 31:0 of the counter, and a write to 0x104 replaces only bits 63:32. The counter does not advance in the cycle it is written.
- R3: While control bit 8 (offset 0x240) is set, the counter advances by one per clock and carries from the low half into the high half. While that bit is clear, the counter holds.
- R4: Control bits 8 (run), 1 (auto-increment) and 0 (compare enable) read back as written, and all other control bits read zero. The compare halves at 0x200 and 0x204 and the step at 0x208 read back as written.
- R5: A match is a 64-bit equality between the counter and the compare value. It counts only while control bit 0 is set.
- R6: A match sets bit 0 of 0x244 at the next edge. Writing 1 to that bit clears it. A match in the same cycle as the clear wins.
- R7: On a match with control bit 1 set, the compare value becomes the compare value plus the zero-extended step at the next edge. Without that bit, the compare value is unchanged.
- R8: `irqOut` is high exactly when the pending bit and bit 0 of 0x248 are both set.
- R9: At 0x110, bit 0 confirms a counter low-half write and bit 1 confirms a high-half write. Each bit is set at the second edge after the write is accepted, stays set, and is cleared by writing 1 to it.
- R10: At 0x24C, bit 0 confirms a compare low write, bit 1 a compare high write, bit 2 a step write and bit 16 a control write. These bits follow the same timing and clearing rule as R9.
- R11: Unmapped offsets read zero, and `regRdata` is zero while `regRd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe, accepted at the rising edge |
| regRd | input | 1 | Read strobe |
| regAddr | input | 12 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| irqOut | output | 1 | Compare interrupt |

## Verification
The assertions assume that `regWr` and `regAddr` are stable around each rising edge. They also assume that the counter is never loaded with a value that the comparator would match in the same cycle the compare value is written. The bench drives all bus signals at the falling edge and issues one register access at a time, so these assumptions hold. It also places compare values well ahead of a counter that is either running or stopped at a known value. A behavioural reference model is updated at every edge, so the interrupt line is compared on every cycle, including during the periodic auto-increment runs.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam logic [11:0] OFF_CNT_LO = 12'h100;
  localparam logic [11:0] OFF_CNT_HI = 12'h104;
  localparam logic [11:0] OFF_CNT_WS = 12'h110;
  localparam logic [11:0] OFF_CMP_LO = 12'h200;
  localparam logic [11:0] OFF_CMP_HI = 12'h204;
  localparam logic [11:0] OFF_STEP   = 12'h208;
  localparam logic [11:0] OFF_CTRL   = 12'h240;
  localparam logic [11:0] OFF_ISTAT  = 12'h244;
  localparam logic [11:0] OFF_IEN    = 12'h248;
  localparam logic [11:0] OFF_WS     = 12'h24C;

  localparam int CTRL_RUN_BIT  = 8;
  localparam int CTRL_AUTO_BIT = 1;
  localparam int CTRL_CEN_BIT  = 0;
  localparam int WS_CTRL_BIT   = 16;

  // write strobes from control to datapath
  typedef struct packed {
    logic cntLo;
    logic cntHi;
    logic cmpLo;
    logic cmpHi;
    logic step;
  } dpWrite_t;

  // operating mode bits held in control
  typedef struct packed {
    logic run;
    logic cmpEn;
    logic autoInc;
  } dpMode_t;
endpackage

// File: rtl/gtmr_datapath.sv
module gtmr_datapath
  import gtmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpWrite_t              wrStb,
  input  dpMode_t               mode,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   cntVal,
  output logic [2*DATA_W-1:0]   cmpVal,
  output logic [DATA_W-1:0]     stepVal,
  output logic                  matchHit
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cmpQ;
  logic [DATA_W-1:0] stepQ;

  assign matchHit = mode.cmpEn && (cntQ == cmpQ);

  // free-running counter with per-half load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (wrStb.cntLo) begin
      cntQ[DATA_W-1:0] <= wdata;
    end else if (wrStb.cntHi) begin
      cntQ[CNT_W-1:DATA_W] <= wdata;
    end else if (mode.run) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  // compare value, self re-arming on match
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else if (wrStb.cmpLo) begin
      cmpQ[DATA_W-1:0] <= wdata;
    end else if (wrStb.cmpHi) begin
      cmpQ[CNT_W-1:DATA_W] <= wdata;
    end else if (matchHit && mode.autoInc) begin
      cmpQ <= cmpQ + CNT_W'(stepQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stepQ <= '0;
    else if (wrStb.step) stepQ <= wdata;
  end

  assign cntVal  = cntQ;
  assign cmpVal  = cmpQ;
  assign stepVal = stepQ;
endmodule

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic [2*DATA_W-1:0]   cntVal,
  input  logic [2*DATA_W-1:0]   cmpVal,
  input  logic [DATA_W-1:0]     stepVal,
  input  logic                  matchHit,
  output dpWrite_t              wrStb,
  output dpMode_t               mode,
  output logic [DATA_W-1:0]     regRdata,
  output logic                  irqOut,
  output logic                  pendFlag,
  output logic                  intEnFlag,
  output logic [1:0]            cntWs,
  output logic [3:0]            cmpWs
);
  localparam int CNT_W = 2 * DATA_W;

  function automatic logic isWr(input logic [11:0] off);
    return regWr && (regAddr == ADDR_W'(off));
  endfunction

  logic ctrlWr, istatWr, ienWr, cntWsWr, gWsWr;
  // delayed strobes: {ctrl, step, cmpHi, cmpLo, cntHi, cntLo}
  logic [5:0] wrDly;
  logic [1:0] cntClr;
  logic [3:0] cmpClr;

  always_comb begin
    wrStb.cntLo = isWr(OFF_CNT_LO);
    wrStb.cntHi = isWr(OFF_CNT_HI);
    wrStb.cmpLo = isWr(OFF_CMP_LO);
    wrStb.cmpHi = isWr(OFF_CMP_HI);
    wrStb.step  = isWr(OFF_STEP);
  end

  assign ctrlWr  = isWr(OFF_CTRL);
  assign istatWr = isWr(OFF_ISTAT);
  assign ienWr   = isWr(OFF_IEN);
  assign cntWsWr = isWr(OFF_CNT_WS);
  assign gWsWr   = isWr(OFF_WS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0;
    end else if (ctrlWr) begin
      mode.run     <= regWdata[CTRL_RUN_BIT];
      mode.cmpEn   <= regWdata[CTRL_CEN_BIT];
      mode.autoInc <= regWdata[CTRL_AUTO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) intEnFlag <= 1'b0;
    else if (ienWr) intEnFlag <= regWdata[0];
  end

  // pending flag: a match outranks a clear
  always_ff @(posedge clk) begin
    if (!rstN) pendFlag <= 1'b0;
    else if (matchHit) pendFlag <= 1'b1;
    else if (istatWr && regWdata[0]) pendFlag <= 1'b0;
  end

  assign irqOut = pendFlag & intEnFlag;

  // write confirmation: one register stage, then sticky set
  assign cntClr = cntWsWr ? regWdata[1:0] : 2'b00;
  assign cmpClr = gWsWr ? {regWdata[WS_CTRL_BIT], regWdata[2:0]} : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrDly <= '0;
      cntWs <= '0;
      cmpWs <= '0;
    end else begin
      wrDly <= {ctrlWr, wrStb.step, wrStb.cmpHi, wrStb.cmpLo, wrStb.cntHi, wrStb.cntLo};
      cntWs <= (cntWs & ~cntClr) | wrDly[1:0];
      cmpWs <= (cmpWs & ~cmpClr) | wrDly[5:2];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      case (regAddr)
        ADDR_W'(OFF_CNT_LO): regRdata = cntVal[DATA_W-1:0];
        ADDR_W'(OFF_CNT_HI): regRdata = cntVal[CNT_W-1:DATA_W];
        ADDR_W'(OFF_CNT_WS): regRdata[1:0] = cntWs;
        ADDR_W'(OFF_CMP_LO): regRdata = cmpVal[DATA_W-1:0];
        ADDR_W'(OFF_CMP_HI): regRdata = cmpVal[CNT_W-1:DATA_W];
        ADDR_W'(OFF_STEP):   regRdata = stepVal;
        ADDR_W'(OFF_CTRL): begin
          regRdata[CTRL_RUN_BIT]  = mode.run;
          regRdata[CTRL_AUTO_BIT] = mode.autoInc;
          regRdata[CTRL_CEN_BIT]  = mode.cmpEn;
        end
        ADDR_W'(OFF_ISTAT):  regRdata[0] = pendFlag;
        ADDR_W'(OFF_IEN):    regRdata[0] = intEnFlag;
        ADDR_W'(OFF_WS): begin
          regRdata[2:0]         = cmpWs[2:0];
          regRdata[WS_CTRL_BIT] = cmpWs[3];
        end
        default: regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gtmr_global_timer.sv
module gtmr_global_timer
  import gtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  localparam int CNT_W = 2 * DATA_W;

  dpWrite_t          wrStb;
  dpMode_t           modeBus;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  cmpVal;
  logic [DATA_W-1:0] stepVal;
  logic              matchHit;
  logic              pendFlag;
  logic              intEnFlag;
  logic [1:0]        cntWs;
  logic [3:0]        cmpWs;

  gtmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata),
    .cntVal(cntVal), .cmpVal(cmpVal), .stepVal(stepVal), .matchHit(matchHit),
    .wrStb(wrStb), .mode(modeBus), .regRdata(regRdata), .irqOut(irqOut),
    .pendFlag(pendFlag), .intEnFlag(intEnFlag), .cntWs(cntWs), .cmpWs(cmpWs)
  );

  gtmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .mode(modeBus), .wdata(regWdata),
    .cntVal(cntVal), .cmpVal(cmpVal), .stepVal(stepVal), .matchHit(matchHit)
  );
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk
  import gtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWr,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                irqOut,
  input logic                pendFlag,
  input logic                intEnFlag,
  input logic [2*DATA_W-1:0] cntVal,
  input logic [2*DATA_W-1:0] cmpVal,
  input logic [DATA_W-1:0]   stepVal,
  input logic                run,
  input logic                cmpEn,
  input logic                autoInc,
  input logic [3:0]          cmpWs
);
  localparam int CNT_W = 2 * DATA_W;

  logic cntWrite, cmpWrite, ctrlWrite, clrWrite;
  assign cntWrite  = regWr && (regAddr == ADDR_W'(OFF_CNT_LO) || regAddr == ADDR_W'(OFF_CNT_HI));
  assign cmpWrite  = regWr && (regAddr == ADDR_W'(OFF_CMP_LO) || regAddr == ADDR_W'(OFF_CMP_HI));
  assign ctrlWrite = regWr && (regAddr == ADDR_W'(OFF_CTRL));
  assign clrWrite  = regWr && (regAddr == ADDR_W'(OFF_WS));

  // R3: running counter steps by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (run && !cntWrite) |=> (cntVal == $past(cntVal) + CNT_W'(1)));

  // R3: stopped counter holds
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !cntWrite) |=> $stable(cntVal));

  // R6: match raises pending
  p_match_pend_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEn && cntVal == cmpVal) |=> pendFlag);

  // R5: no pending rise while comparator disabled
  p_no_match_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpEn && !pendFlag) |=> !pendFlag);

  // R7: compare value advances by the step on a match
  p_auto_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEn && autoInc && cntVal == cmpVal && !cmpWrite)
      |=> (cmpVal == $past(cmpVal) + CNT_W'($past(stepVal))));

  // R8: interrupt only with flag and enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (intEnFlag && pendFlag));

  // R10: control write confirmed two edges later
  p_ctrl_ws_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && !clrWrite) |=> ##1 cmpWs[3]);
endmodule

bind gtmr_global_timer gtmr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .irqOut(irqOut),
  .pendFlag(pendFlag), .intEnFlag(intEnFlag), .cntVal(cntVal), .cmpVal(cmpVal),
  .stepVal(stepVal), .run(modeBus.run), .cmpEn(modeBus.cmpEn),
  .autoInc(modeBus.autoInc), .cmpWs(cmpWs)
);

// File: tb/tb_gtmr_global_timer.sv
`timescale 1ns/1ps
module tb_gtmr_global_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  gtmr_global_timer dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [63:0] mCnt, mCmp, nCnt, nCmp;
  logic [31:0] mStep;
  logic mRun, mCen, mAuto, mIen, mPend, mHit, pWr;
  logic [11:0] pAddr;
  logic [1:0] mCntWs;
  logic [3:0] mWs;
  logic [1:0] cClr;
  logic [3:0] gClr, gSet;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt <= 0; mCmp <= 0; mStep <= 0; mRun <= 0; mCen <= 0; mAuto <= 0;
      mIen <= 0; mPend <= 0; pWr <= 0; pAddr <= 0; mCntWs <= 0; mWs <= 0;
    end else begin
      mHit = mCen && (mCnt == mCmp);
      nCnt = mCnt;
      if (regWr && regAddr == 12'h100) nCnt[31:0] = regWdata;
      else if (regWr && regAddr == 12'h104) nCnt[63:32] = regWdata;
      else if (mRun) nCnt = mCnt + 64'd1;
      nCmp = mCmp;
      if (regWr && regAddr == 12'h200) nCmp[31:0] = regWdata;
      else if (regWr && regAddr == 12'h204) nCmp[63:32] = regWdata;
      else if (mHit && mAuto) nCmp = mCmp + {32'd0, mStep};
      mCnt <= nCnt;
      mCmp <= nCmp;
      if (regWr && regAddr == 12'h208) mStep <= regWdata;
      if (regWr && regAddr == 12'h240) begin
        mRun <= regWdata[8]; mAuto <= regWdata[1]; mCen <= regWdata[0];
      end
      if (regWr && regAddr == 12'h248) mIen <= regWdata[0];
      if (mHit) mPend <= 1'b1;
      else if (regWr && regAddr == 12'h244 && regWdata[0]) mPend <= 1'b0;
      cClr = (regWr && regAddr == 12'h110) ? regWdata[1:0] : 2'b00;
      gClr = (regWr && regAddr == 12'h24C) ? {regWdata[16], regWdata[2:0]} : 4'b0000;
      gSet = {pWr && pAddr == 12'h240, pWr && pAddr == 12'h208,
              pWr && pAddr == 12'h204, pWr && pAddr == 12'h200};
      mCntWs <= (mCntWs & ~cClr) | {pWr && pAddr == 12'h104, pWr && pAddr == 12'h100};
      mWs <= (mWs & ~gClr) | gSet;
      pWr <= regWr;
      pAddr <= regAddr;
    end
  end

  function automatic logic [31:0] mRead(input logic [11:0] a);
    case (a)
      12'h100: return mCnt[31:0];
      12'h104: return mCnt[63:32];
      12'h110: return {30'd0, mCntWs};
      12'h200: return mCmp[31:0];
      12'h204: return mCmp[63:32];
      12'h208: return mStep;
      12'h240: return {23'd0, mRun, 6'd0, mAuto, mCen};
      12'h244: return {31'd0, mPend};
      12'h248: return {31'd0, mIen};
      12'h24C: return {15'd0, mWs[3], 13'd0, mWs[2:0]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // interrupt line compared every cycle (R8)
  always @(negedge clk) begin
    if (rstN) chk("R8 irq", {31'd0, irqOut}, {31'd0, mPend && mIen});
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1;
    chk(req, regRdata, mRead(a));
    regRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    rd("R1 cnt lo", 12'h100); chk("R1 cnt lo zero", regRdata, 32'd0);
    rd("R1 cnt hi", 12'h104);
    rd("R1 ctrl", 12'h240);
    rd("R1 pend", 12'h244);
    rd("R1 ws", 12'h24C);
    rd("R1 cnt ws", 12'h110);
    // R2 half writes
    wr(12'h104, 32'h0000_0001);
    wr(12'h100, 32'hFFFF_FFF0);
    rd("R2 lo", 12'h100); chk("R2 lo value", regRdata, 32'hFFFF_FFF0);
    rd("R2 hi", 12'h104); chk("R2 hi value", regRdata, 32'h0000_0001);
    // R9 counter confirmation
    rd("R9 cnt ws", 12'h110); chk("R9 both set", regRdata, 32'd3);
    wr(12'h110, 32'd1);
    rd("R9 clr lo", 12'h110); chk("R9 lo cleared", regRdata, 32'd2);
    wr(12'h110, 32'd2);
    rd("R9 clr hi", 12'h110);
    // R3 running with carry
    wr(12'h240, 32'h0000_0100);
    idle(25);
    rd("R3 lo", 12'h100);
    rd("R3 hi carry", 12'h104); chk("R3 hi carried", regRdata, 32'd2);
    // R2 high write while running
    wr(12'h104, 32'h0000_0005);
    rd("R2 hi run", 12'h104);
    rd("R2 lo run", 12'h100);
    // R4 readback and R11
    wr(12'h240, 32'hFFFF_FFFF);
    rd("R4 ctrl", 12'h240); chk("R4 ctrl bits", regRdata, 32'h0000_0103);
    wr(12'h240, 32'h0);
    wr(12'h208, 32'h0000_0008);
    wr(12'h204, 32'h0000_0000);
    wr(12'h200, 32'h0000_0040);
    rd("R4 step", 12'h208);
    rd("R4 cmp lo", 12'h200);
    rd("R4 cmp hi", 12'h204);
    rd("R11 unmapped", 12'h300); chk("R11 zero", regRdata, 32'd0);
    @(negedge clk); regAddr = 12'h100; #1; chk("R11 no rd", regRdata, 32'd0);
    // R10 global confirmation
    rd("R10 ws", 12'h24C); chk("R10 all set", regRdata, 32'h0001_0007);
    wr(12'h24C, 32'h0001_0005);
    rd("R10 part clr", 12'h24C); chk("R10 bit1 left", regRdata, 32'h0000_0002);
    wr(12'h24C, 32'h0000_0002);
    rd("R10 clr", 12'h24C);
    // R5 comparator disabled: equal values do not match
    wr(12'h104, 32'd0);
    wr(12'h100, 32'd0);
    wr(12'h240, 32'h0000_0100);
    idle(80);
    rd("R5 no pend", 12'h244); chk("R5 pend low", regRdata, 32'd0);
    // R6 one-shot match
    wr(12'h240, 32'h0);
    wr(12'h100, 32'd0);
    wr(12'h248, 32'd1);
    wr(12'h240, 32'h0000_0101);
    idle(80);
    rd("R6 pend", 12'h244); chk("R6 pend set", regRdata, 32'd1);
    rd("R7 no auto cmp", 12'h200); chk("R7 cmp kept", regRdata, 32'h40);
    wr(12'h244, 32'd1);
    rd("R6 cleared", 12'h244); chk("R6 pend clear", regRdata, 32'd0);
    // R7 periodic re-arm
    wr(12'h240, 32'h0);
    wr(12'h100, 32'd0);
    wr(12'h200, 32'd20);
    wr(12'h240, 32'h0000_0103);
    idle(60);
    rd("R7 cmp advanced", 12'h200);
    rd("R7 pend", 12'h244);
    wr(12'h244, 32'd1);
    idle(10);
    rd("R7 re-pend", 12'h244);
    // R8 enable off masks interrupt
    wr(12'h248, 32'd0);
    idle(30);
    rd("R8 pend kept", 12'h244); chk("R8 pend still", regRdata, 32'd1);
    chk("R8 masked", {31'd0, irqOut}, 32'd0);
    wr(12'h240, 32'h0);
    rd("R3 stopped", 12'h100);
    idle(5);
    rd("R3 held", 12'h100);
    summary();
  end
endmodule